// File: doc/BRIEF.md
# Scatter-Gather Bit-Inversion Engine

This block is a memory-mastering engine that software starts with a doorbell. It walks a chain of descriptor tables in memory. For every data segment the tables describe, it reads each 8-byte word, inverts every bit and writes the result back to the same address. When the list ends, it raises a sticky completion flag that software polls. One job can cover a large, fragmented buffer, because any table may hand control to another table placed elsewhere in memory.

Software programs a 64-bit table address through two 32-bit registers. The table size and the doorbell share a control word, and the completion flag sits in a status word. The engine makes one memory request at a time over a plain request/response port with 64-bit addresses and data. Byte enables protect the bytes that lie past the end of a segment whose length is not a multiple of eight.

Top module: `sg_invert_dma`

## Requirements
- R1: The register file has four words, selected by `reg_addr`. Word 0 is the low half of the table address and word 1 is the high half, both readable. Word 2 holds the table entry count in bits [8:0] and reads back the count. Word 3 bit 0 is the completion flag.
- R2: Writing word 2 with bit 31 set starts a job. The job uses the current table address registers and the entry count carried in that same write. A count of 0 finishes the job at once, with no memory request.
- R3: An entry is 16 bytes and is fetched as two 8-byte reads, first at the entry address and then at the entry address plus 8. The first word is the segment address. In the second word, bits [31:0] give the length in bytes and bit 32 is the chain flag.
- R4: Every byte of a data segment is replaced in memory by its bitwise inverse. The engine reads each 8-byte word and then writes it back to the same address. Segment addresses are 8-byte aligned.
- R5: On the last word of a segment shorter than 8 bytes from its end, only the low enables for the remaining bytes are set. Bytes past the segment end stay unchanged.
- R6: An entry with the chain flag set moves the engine to a new table at the entry's address. The entry's length field gives the new table's entry count.
- R7: An entry whose address and length are both zero ends the job. Using up a table's entry count without a chain entry also ends the job, and no entry beyond the count is read.
- R8: A non-chain entry with length 0 and a nonzero address is skipped, and no data at that address changes.
- R9: The completion flag is set when a job ends. It stays set until software writes 1 to word 3 bit 0. Writing 0 to that bit has no effect.
- R10: A doorbell written while a job is running is ignored. Neither the running job nor memory is affected by it.
- R11: At most one request is outstanding. `mem_req` and its address stay asserted and stable until the cycle in which `mem_rsp` is high. No request is made while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory request valid, held until response |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 64 | Byte address, 8-byte aligned |
| mem_wdata | output | 64 | Write data |
| mem_be | output | 8 | Byte enables for writes (bit n = byte n) |
| mem_rsp | input | 1 | One-cycle response; completes the current request |
| mem_rdata | input | 64 | Read data, valid with `mem_rsp` |

## Verification
Random jobs vary the segment count, the entries per table and the segment lengths, and the memory latency changes from request to request. This exposes errors in chain following, table accounting and partial-word enables. Directed cases target the edges of each rule, and each one tells a different fault apart:
- a single aligned segment;
- a 13-byte segment, whose neighbour bytes must survive;
- a zero-length entry that must be skipped;
- a table whose count runs out just before a trap entry;
- a zero count at the doorbell;
- a second doorbell that points at a trap buffer while a job runs.

Each job is judged by comparing the whole memory image with a model built from the segment list. The engine's walk is not restated in that model.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int unsigned BEAT_BYTES = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECODE, ST_READ, ST_WRITE, ST_DONE
  } sgi_state_e;

  // bytes consumed by one beat given the bytes left in the segment
  function automatic logic [31:0] beat_take(input logic [31:0] left);
    return (left >= 32'(BEAT_BYTES)) ? 32'(BEAT_BYTES) : left;
  endfunction

  // low-contiguous byte enables covering the bytes left (1..8)
  function automatic logic [7:0] beat_be(input logic [31:0] left);
    if (left >= 32'(BEAT_BYTES)) return 8'hFF;
    return 8'hFF >> (4'd8 - left[3:0]);
  endfunction
endpackage

// File: rtl/sgi_regs.sv
module sgi_regs #(
  parameter int SIZE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [31:0]       wdata,
  input  logic              busy,
  input  logic              job_end,
  output logic [31:0]       rdata,
  output logic [63:0]       base,
  output logic [SIZE_W-1:0] start_size,
  output logic              start,
  output logic              done
);
  logic [31:0]       base_lo_q, base_hi_q;
  logic [SIZE_W-1:0] size_q;
  logic              clr_done;

  assign start      = wr && (addr == 2'd2) && wdata[31] && !busy;
  assign start_size = wdata[SIZE_W-1:0];
  assign base       = {base_hi_q, base_lo_q};
  assign clr_done   = wr && (addr == 2'd3) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_lo_q <= '0;
      base_hi_q <= '0;
      size_q    <= '0;
      done      <= 1'b0;
    end else begin
      if (wr) begin
        case (addr)
          2'd0:    base_lo_q <= wdata;
          2'd1:    base_hi_q <= wdata;
          2'd2:    size_q    <= wdata[SIZE_W-1:0];
          default: ;
        endcase
      end
      if (job_end)       done <= 1'b1;
      else if (clr_done) done <= 1'b0;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = base_lo_q;
      2'd1:    rdata = base_hi_q;
      2'd2:    rdata = 32'(size_q);
      default: rdata = {31'd0, done};
    endcase
  end
endmodule

// File: rtl/sgi_beat.sv
module sgi_beat
  import sgi_pkg::*;
(
  input  logic [31:0] seg_left,
  input  logic [63:0] rd_word,
  output logic [63:0] wr_word,
  output logic [7:0]  be,
  output logic [31:0] take,
  output logic        last
);
  assign wr_word = ~rd_word;
  assign be      = beat_be(seg_left);
  assign take    = beat_take(seg_left);
  assign last    = (seg_left == take);
endmodule

// File: rtl/sgi_walker.sv
module sgi_walker
  import sgi_pkg::*;
#(
  parameter int SIZE_W      = 9,
  parameter int ENTRY_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [63:0]       base,
  input  logic [SIZE_W-1:0] start_size,
  output logic              mem_req,
  output logic              mem_we,
  output logic [63:0]       mem_addr,
  output logic [63:0]       mem_wdata,
  output logic [7:0]        mem_be,
  input  logic              mem_rsp,
  input  logic [63:0]       mem_rdata,
  output logic              busy,
  output logic              job_end
);
  localparam logic [63:0] ENT_STEP = 64'(ENTRY_BYTES);
  localparam logic [63:0] HALF_OFF = 64'(ENTRY_BYTES / 2);

  sgi_state_e        state;
  logic              half;
  logic [63:0]       tbl_ptr, ent_addr, ent_hi, seg_ptr, data_q;
  logic [SIZE_W-1:0] tbl_left;
  logic [31:0]       seg_left, take;
  logic [31:0]       ent_len;
  logic              ent_chain, ent_end, seg_last;
  logic [63:0]       inv_word;
  logic [7:0]        beat_en;

  sgi_beat u_beat (
    .seg_left (seg_left),
    .rd_word  (data_q),
    .wr_word  (inv_word),
    .be       (beat_en),
    .take     (take),
    .last     (seg_last)
  );

  assign ent_len   = ent_hi[31:0];
  assign ent_chain = ent_hi[32];
  assign ent_end   = (ent_addr == 64'd0) && (ent_len == 32'd0);

  assign busy      = (state != ST_IDLE);
  assign job_end   = (state == ST_DONE);
  assign mem_req   = (state == ST_FETCH) || (state == ST_READ) || (state == ST_WRITE);
  assign mem_we    = (state == ST_WRITE);
  assign mem_addr  = (state == ST_FETCH) ? (tbl_ptr + (half ? HALF_OFF : 64'd0)) : seg_ptr;
  assign mem_wdata = inv_word;
  assign mem_be    = (state == ST_WRITE) ? beat_en : 8'hFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      half     <= 1'b0;
      tbl_ptr  <= '0;
      tbl_left <= '0;
      ent_addr <= '0;
      ent_hi   <= '0;
      seg_ptr  <= '0;
      seg_left <= '0;
      data_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          tbl_ptr  <= base;
          tbl_left <= start_size;
          half     <= 1'b0;
          state    <= (start_size == '0) ? ST_DONE : ST_FETCH;
        end
        ST_FETCH: if (mem_rsp) begin
          if (!half) begin
            ent_addr <= mem_rdata;
            half     <= 1'b1;
          end else begin
            ent_hi   <= mem_rdata;
            half     <= 1'b0;
            state    <= ST_DECODE;
          end
        end
        ST_DECODE: begin
          if (ent_end) begin
            state <= ST_DONE;
          end else if (ent_chain) begin
            tbl_ptr  <= ent_addr;
            tbl_left <= ent_len[SIZE_W-1:0];
            state    <= (ent_len == 32'd0) ? ST_DONE : ST_FETCH;
          end else begin
            tbl_ptr  <= tbl_ptr + ENT_STEP;
            tbl_left <= tbl_left - 1'b1;
            if (ent_len == 32'd0) begin
              state <= (tbl_left == SIZE_W'(1)) ? ST_DONE : ST_FETCH;
            end else begin
              seg_ptr  <= ent_addr;
              seg_left <= ent_len;
              state    <= ST_READ;
            end
          end
        end
        ST_READ: if (mem_rsp) begin
          data_q <= mem_rdata;
          state  <= ST_WRITE;
        end
        ST_WRITE: if (mem_rsp) begin
          seg_ptr  <= seg_ptr + 64'(BEAT_BYTES);
          seg_left <= seg_left - take;
          if (seg_last) state <= (tbl_left == '0) ? ST_DONE : ST_FETCH;
          else          state <= ST_READ;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sg_invert_dma.sv
module sg_invert_dma #(
  parameter int TBL_MAX     = 256,
  parameter int ENTRY_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [63:0] mem_addr,
  output logic [63:0] mem_wdata,
  output logic [7:0]  mem_be,
  input  logic        mem_rsp,
  input  logic [63:0] mem_rdata
);
  localparam int SIZE_W = $clog2(TBL_MAX + 1);

  logic              busy_w, job_end_w, start_w, done_w;
  logic [63:0]       base_w;
  logic [SIZE_W-1:0] size_w;

  sgi_regs #(.SIZE_W(SIZE_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .busy       (busy_w),
    .job_end    (job_end_w),
    .rdata      (reg_rdata),
    .base       (base_w),
    .start_size (size_w),
    .start      (start_w),
    .done       (done_w)
  );

  sgi_walker #(.SIZE_W(SIZE_W), .ENTRY_BYTES(ENTRY_BYTES)) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_w),
    .base       (base_w),
    .start_size (size_w),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_be     (mem_be),
    .mem_rsp    (mem_rsp),
    .mem_rdata  (mem_rdata),
    .busy       (busy_w),
    .job_end    (job_end_w)
  );
endmodule

// File: rtl/sgi_checker.sv
module sgi_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic [63:0] mem_addr,
  input logic [63:0] mem_wdata,
  input logic [7:0]  mem_be,
  input logic        mem_rsp,
  input logic [63:0] mem_rdata,
  input logic        busy,
  input logic        job_end,
  input logic        done
);
  logic [63:0] last_rd_data, last_rd_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_rd_data <= '0;
      last_rd_addr <= '0;
    end else if (mem_req && !mem_we && mem_rsp) begin
      last_rd_data <= mem_rdata;
      last_rd_addr <= mem_addr;
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rsp) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R11
  AST_BE_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != 8'd0 && ((mem_be & (mem_be + 8'd1)) == 8'd0))); // R5
  AST_WR_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata == ~last_rd_data)); // R4
  AST_WR_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == last_rd_addr)); // R4
  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    job_end |=> done); // R9
endmodule

bind sg_invert_dma sgi_checker i_sgi_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_be    (mem_be),
  .mem_rsp   (mem_rsp),
  .mem_rdata (mem_rdata),
  .busy      (busy_w),
  .job_end   (job_end_w),
  .done      (done_w)
);

// File: tb/test_sg_invert_dma.sv
`timescale 1ns/1ps
module test_sg_invert_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr, mem_wdata;
  logic [7:0]  mem_be;
  logic        mem_rsp = 1'b0;
  logic [63:0] mem_rdata = 64'd0;

  int checks = 0;
  int fails  = 0;
  int req_cycles = 0;
  int unsigned lat = 0;

  logic [63:0] mem  [4096];
  logic [63:0] expm [4096];
  logic [63:0] sa [64];
  int          sl [64];

  always #2 clk = ~clk;

  sg_invert_dma i_sg_invert_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rsp(mem_rsp), .mem_rdata(mem_rdata)
  );

  // memory model: one request at a time, random latency 0..2 cycles
  always @(posedge clk) begin
    if (mem_req) req_cycles <= req_cycles + 1;
    if (!rst_n) begin
      mem_rsp <= 1'b0;
      lat <= 0;
    end else if (mem_rsp) begin
      mem_rsp <= 1'b0;
    end else if (mem_req) begin
      if (lat != 0) lat <= lat - 1;
      else begin
        if (mem_we) begin
          for (int b = 0; b < 8; b++)
            if (mem_be[b]) mem[mem_addr[14:3]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        end else begin
          mem_rdata <= mem[mem_addr[14:3]];
        end
        mem_rsp <= 1'b1;
        lat <= $urandom_range(2, 0);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic put(input logic [63:0] addr, input logic [63:0] w);
    mem[addr[14:3]]  = w;
    expm[addr[14:3]] = w;
  endtask

  task automatic fill(input logic [63:0] addr, input int words);
    for (int i = 0; i < words; i++) put(addr + 64'(8 * i), {$urandom, $urandom});
  endtask

  task automatic invert_seg(input logic [63:0] addr, input int len);
    for (int i = 0; i < len; i++) begin
      logic [63:0] a;
      a = addr + 64'(i);
      expm[a[14:3]][a[2:0]*8 +: 8] = ~expm[a[14:3]][a[2:0]*8 +: 8];
    end
  endtask

  function automatic int tsize(input int rem, input int per, input bit term);
    return (rem > per) ? per + 1 : rem + (term ? 1 : 0);
  endfunction

  // lay out sa/sl[0..n-1] in tables spaced 0x200 apart starting at tb
  task automatic build_tables(input int n, input int per, input logic [63:0] tb,
                              input bit term, output int first_size);
    int dn, t;
    dn = 0; t = 0;
    first_size = tsize(n, per, term);
    if (n == 0 && term) begin
      put(tb, 64'd0); put(tb + 64'd8, 64'd0);
    end
    while (dn < n) begin
      int cnt;
      logic [63:0] bt;
      cnt = (n - dn > per) ? per : n - dn;
      bt = tb + 64'(t * 32'h200);
      for (int k = 0; k < cnt; k++) begin
        put(bt + 64'(16 * k), sa[dn + k]);
        put(bt + 64'(16 * k + 8), {32'h0, 32'(sl[dn + k])});
      end
      dn += cnt;
      if (dn < n) begin
        put(bt + 64'(16 * cnt), bt + 64'h200);   // R6 chain entry
        put(bt + 64'(16 * cnt + 8), {32'h1, 32'(tsize(n - dn, per, term))});
      end else if (term) begin
        put(bt + 64'(16 * cnt), 64'd0);          // R7 terminator
        put(bt + 64'(16 * cnt + 8), 64'd0);
      end
      t++;
    end
  endtask

  task automatic gen_segs(input int n, input logic [63:0] slot_base);
    for (int j = 0; j < n; j++) begin
      logic [63:0] slot;
      slot = slot_base + 64'(j * 32'h100);
      fill(slot, 32);
      sa[j] = slot + 64'(8 * $urandom_range(7, 0));
      sl[j] = ($urandom_range(9, 0) == 0) ? 0 : $urandom_range(200, 1);
    end
  endtask

  task automatic wait_done(input string req);
    logic [31:0] s;
    bit seen;
    seen = 0;
    for (int i = 0; i < 30000 && !seen; i++) begin
      rd(2'd3, s);
      seen = s[0];
    end
    check(seen, req, "completion flag after job", 64'(s[0]), 64'd1);
    wr(2'd3, 32'd1);
  endtask

  task automatic compare_mem(input string req, input string what);
    int mism, first;
    mism = 0; first = 0;
    for (int i = 0; i < 4096; i++)
      if (mem[i] !== expm[i]) begin
        if (mism == 0) first = i;
        mism++;
      end
    check(mism == 0, req, what, mem[first], expm[first]);
  endtask

  task automatic ring(input logic [63:0] base, input int size);
    wr(2'd0, base[31:0]);
    wr(2'd1, base[63:32]);
    wr(2'd2, 32'h8000_0000 | 32'(size));
  endtask

  task automatic run_job(input int n, input int per, input string req, input string what);
    int fs;
    build_tables(n, per, 64'h400, 1'b1, fs);
    for (int j = 0; j < n; j++) invert_seg(sa[j], sl[j]);
    ring(64'h400, fs);
    wait_done(req);
    compare_mem(req, what);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int fs, rq;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4096; i++) begin mem[i] = 64'd0; expm[i] = 64'd0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(2'd3, d); check(d == 0, "R9", "flag after reset", 64'(d), 64'd0);
    check(mem_req == 1'b0, "R11", "no request after reset", 64'(mem_req), 64'd0);

    // R1 register readback, no doorbell
    wr(2'd0, 32'h1234_5678); wr(2'd1, 32'h9abc_def0); wr(2'd2, 32'd5);
    rd(2'd0, d); check(d == 32'h1234_5678, "R1", "base low readback", 64'(d), 64'h1234_5678);
    rd(2'd1, d); check(d == 32'h9abc_def0, "R1", "base high readback", 64'(d), 64'h9abc_def0);
    rd(2'd2, d); check(d == 32'd5, "R1", "count readback", 64'(d), 64'd5);
    repeat (5) @(negedge clk);
    check(req_cycles == 0, "R2", "no job without doorbell bit", 64'(req_cycles), 64'd0);

    // R4/R3 single aligned segment
    fill(64'h4000, 16); sa[0] = 64'h4000; sl[0] = 64;
    run_job(1, 4, "R4", "single aligned segment");

    // R5 13-byte segment, neighbours intact
    fill(64'h4100, 8); sa[0] = 64'h4108; sl[0] = 13;
    run_job(1, 4, "R5", "partial last word");

    // R8 zero-length entry between two segments
    gen_segs(3, 64'h4000); sl[0] = 24; sl[1] = 0; sl[2] = 17;
    run_job(3, 4, "R8", "zero-length entry skipped");

    // R6 chained tables, 10 segments, 3 per table
    gen_segs(10, 64'h4000);
    for (int j = 0; j < 10; j++) if (sl[j] == 0) sl[j] = 40;
    run_job(10, 3, "R6", "chained tables");

    // R7 count exhausted: trap entry just past the count
    gen_segs(3, 64'h4000);
    build_tables(3, 8, 64'h400, 1'b0, fs);
    for (int j = 0; j < 3; j++) invert_seg(sa[j], sl[j]);
    fill(64'h6800, 4);
    put(64'h430, 64'h6800); put(64'h438, {32'h0, 32'd16});
    ring(64'h400, fs);
    wait_done("R7");
    compare_mem("R7", "stop at table count");

    // R2 zero count: done at once, no request
    rq = req_cycles;
    ring(64'h420, 0);
    wait_done("R2");
    check(req_cycles == rq, "R2", "zero count makes no request", 64'(req_cycles - rq), 64'd0);
    compare_mem("R2", "zero count memory unchanged");

    // R10 doorbell while busy
    fill(64'h6000, 8); sa[0] = 64'h6000; sl[0] = 64;
    build_tables(1, 1, 64'h3800, 1'b1, fs);
    gen_segs(20, 64'h4000);
    build_tables(20, 4, 64'h400, 1'b1, fs);
    for (int j = 0; j < 20; j++) invert_seg(sa[j], sl[j]);
    ring(64'h400, fs);
    wr(2'd0, 32'h3800);
    wr(2'd2, 32'h8000_0002);
    wait_done("R10");
    repeat (40) @(negedge clk);
    compare_mem("R10", "second doorbell ignored");

    // R9 write-one-to-clear
    ring(64'h420, 0);
    repeat (4) @(negedge clk);
    wr(2'd3, 32'd0);
    rd(2'd3, d); check(d[0] == 1'b1, "R9", "flag kept after writing 0", 64'(d[0]), 64'd1);
    wr(2'd3, 32'd1);
    rd(2'd3, d); check(d[0] == 1'b0, "R9", "flag cleared by writing 1", 64'(d[0]), 64'd0);

    // random jobs
    for (int r = 0; r < 6; r++) begin
      int n, per;
      n = $urandom_range(30, 1);
      per = $urandom_range(8, 2);
      gen_segs(n, 64'h4000);
      run_job(n, per, "R6", $sformatf("random job %0d", r));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule